// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block keeps the burst-related fields of an SDRAM mode register and turns a starting column, taken from a READ or WRITE command, into the column address of every beat of that burst. Bursts of 1, 2, 4 or 8 beats stay inside an aligned block of that size and walk it in either sequential or interleaved order. A full-page burst walks the whole row and keeps going until it is stopped.

The controller loads the mode op-code with a one-cycle strobe. It starts a burst with a start strobe, the start column and a write flag. The column stream leaves on a valid/ready pair. A beat is consumed on a clock edge where `col_valid` and `col_ready` are both high. While `col_valid` is high and `col_ready` is low, the address and the last-beat flag hold, and the beat is not lost. The stream never waits on anything else. A stop or a new start overrides back-pressure. The held CAS latency goes out as a plain pin. A reserved code raises a sticky error pin.

The column width is set by `COL_W` and may be 9 or 10 bits. This gives rows of 512 or 1024 columns.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, `col_valid`, `col_last` and `cfg_error` are 0 and `cas_lat` is 3. The held burst length is 1, so a burst started right after reset has exactly one beat.
- R2: A `mode_load` captures the following op-code fields, which apply to bursts started after that edge:
  - bits [2:0] give the burst length: 000=1, 001=2, 010=4, 011=8, 111=full page.
  - bit 3 gives the burst type: 0 is sequential, 1 is interleaved.
  - bits [6:4] give the CAS latency, output on `cas_lat`: 010 means 2, 011 means 3.
  - bit 9 set to 1 makes WRITE bursts single-beat.
  - bits [8:7] and [11:10] are ignored.
- R3: A load whose length code or latency code is reserved sets `cfg_error`. `cfg_error` stays set until reset. The reserved field keeps its previous legal value, and the other fields of that load still take effect.
- R4: The cycle after `burst_start`, `col_valid` is 1 and `col_addr` equals `start_col`.
- R5: In a sequential burst of length L (2, 4 or 8), the low log2(L) column bits count up modulo L from the start value. The upper bits stay fixed.
- R6: In an interleaved burst of length L, the low log2(L) bits of beat k equal the start's low bits XOR k. The upper bits stay fixed.
- R7: A burst of length 1 has one beat, carrying `col_last`. The burst-type bit has no effect on it.
- R8: A full-page burst counts up by one per consumed beat and wraps from 2^COL_W-1 to 0. It never raises `col_last`, and it runs until a stop or a new start.
- R9: With write-single set, a WRITE burst has one beat, while a READ burst keeps the programmed length and order. With write-single clear, a WRITE burst uses the programmed length.
- R10: A beat advances only on an edge with `col_valid` and `col_ready` both high. While `col_ready` is low, `col_addr`, `col_last` and `col_valid` hold.
- R11: `col_last` is high only on the final beat of a fixed-length burst. The cycle after that beat is consumed, `col_valid` is 0 unless a new start arrived.
- R12: `burst_stop` ends an active burst, and `col_valid` is 0 on the next cycle. A stop while idle has no effect. A start in the same cycle as a stop wins.
- R13: A start during an active burst begins the new burst on the next cycle, with no idle cycle, at the new start column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_load | input | 1 | Load strobe for the mode op-code |
| mode_opcode | input | 12 | Mode op-code (fields in R2) |
| burst_start | input | 1 | Start a burst at `start_col` |
| burst_write | input | 1 | 1 when the starting command is a WRITE |
| start_col | input | COL_W | Starting column of the burst |
| burst_stop | input | 1 | Terminate the active burst |
| col_ready | input | 1 | Consumer accepts the current beat |
| col_valid | output | 1 | A beat column is presented |
| col_addr | output | COL_W | Column address of the current beat |
| col_last | output | 1 | Current beat is the final beat of a fixed-length burst |
| cas_lat | output | 2 | Held CAS latency (2 or 3) |
| cfg_error | output | 1 | Sticky flag: a reserved code was loaded |

## Verification
The hardest situation to reach is the full-page wrap past the top of the row while the burst is still running. That needs more than a row's worth of consumed beats with no stop. The stimulus starts a full-page burst two columns below the top on a 10-bit instance and, through the same inputs, on a 9-bit instance. It checks the wrap to zero on both, then lets more than a thousand beats stream and checks the computed column on both widths before stopping. A second hard case is a new start landing in the same cycle as a consumed beat, and in the same cycle as a stop. The stimulus times these strobes on a chosen beat.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

  // Op-code field positions (R2)
  localparam int OP_LEN_LSB = 0;
  localparam int OP_TYPE_BIT = 3;
  localparam int OP_LAT_LSB = 4;
  localparam int OP_WSGL_BIT = 9;

  typedef enum logic [2:0] {
    LEN_1    = 3'b000,
    LEN_2    = 3'b001,
    LEN_4    = 3'b010,
    LEN_8    = 3'b011,
    LEN_PAGE = 3'b111
  } len_code_e;

  typedef struct packed {
    logic [2:0] len_code;
    logic       ilv;
    logic       wr_single;
    logic       lat_three;
  } mode_t;

  function automatic logic len_code_ok(input logic [2:0] c);
    return (c == LEN_1) || (c == LEN_2) || (c == LEN_4) ||
           (c == LEN_8) || (c == LEN_PAGE);
  endfunction

  function automatic logic lat_code_ok(input logic [2:0] c);
    return (c == 3'b010) || (c == 3'b011);
  endfunction

endpackage

// File: rtl/colgen_mode_reg.sv
module colgen_mode_reg
  import colgen_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [11:0] opcode,
  output mode_t       mode,
  output logic        cfg_err
);

  logic [2:0] len_f;
  logic [2:0] lat_f;
  logic       len_ok;
  logic       lat_ok;
  logic       unused_opcode_bits;

  assign len_f  = opcode[OP_LEN_LSB +: 3];
  assign lat_f  = opcode[OP_LAT_LSB +: 3];
  assign len_ok = len_code_ok(len_f);
  assign lat_ok = lat_code_ok(lat_f);
  assign unused_opcode_bits = ^{opcode[11:10], opcode[8:7]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode.len_code  <= LEN_1;
      mode.ilv       <= 1'b0;
      mode.wr_single <= 1'b0;
      mode.lat_three <= 1'b1;
      cfg_err        <= 1'b0;
    end else if (load) begin
      mode.ilv       <= opcode[OP_TYPE_BIT];
      mode.wr_single <= opcode[OP_WSGL_BIT];
      if (len_ok) mode.len_code  <= len_f;
      if (lat_ok) mode.lat_three <= lat_f[0];
      if (!len_ok || !lat_ok) cfg_err <= 1'b1;
    end
  end

endmodule

// File: rtl/colgen_beat_seq.sv
module colgen_beat_seq
  import colgen_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       len_code,
  input  logic             ilv_mode,
  input  logic             wr_single,
  input  logic             start,
  input  logic             is_write,
  input  logic [COL_W-1:0] start_col,
  input  logic             stop,
  input  logic             ready,
  output logic             active,
  output logic [COL_W-1:0] base,
  output logic [COL_W-1:0] idx,
  output logic [COL_W-1:0] mask,
  output logic             ilv,
  output logic             last
);

  logic [2:0] eff_code;
  logic [COL_W-1:0] new_mask;
  logic full;
  logic at_end;

  assign eff_code = (is_write && wr_single) ? LEN_1 : len_code;

  always_comb begin
    case (eff_code)
      LEN_2:    new_mask = COL_W'(1);
      LEN_4:    new_mask = COL_W'(3);
      LEN_8:    new_mask = COL_W'(7);
      LEN_PAGE: new_mask = '1;
      default:  new_mask = '0;
    endcase
  end

  assign at_end = (idx == mask) && !full;
  assign last   = active && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      base   <= '0;
      idx    <= '0;
      mask   <= '0;
      ilv    <= 1'b0;
      full   <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
      base   <= start_col;
      idx    <= '0;
      mask   <= new_mask;
      full   <= (eff_code == LEN_PAGE);
      ilv    <= ilv_mode && (eff_code != LEN_PAGE) && (eff_code != LEN_1);
    end else if (stop) begin
      active <= 1'b0;
    end else if (active && ready) begin
      if (at_end) active <= 1'b0;
      else        idx    <= idx + 1'b1;
    end
  end

endmodule

// File: rtl/colgen_addr_map.sv
module colgen_addr_map #(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] idx,
  input  logic [COL_W-1:0] mask,
  input  logic             ilv,
  output logic [COL_W-1:0] col
);

  logic [COL_W-1:0] mixed;

  assign mixed = ilv ? (base ^ idx) : (base + idx);

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign col[b] = mask[b] ? mixed[b] : base[b];
  end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import colgen_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_load,
  input  logic [11:0]      mode_opcode,
  input  logic             burst_start,
  input  logic             burst_write,
  input  logic [COL_W-1:0] start_col,
  input  logic             burst_stop,
  input  logic             col_ready,
  output logic             col_valid,
  output logic [COL_W-1:0] col_addr,
  output logic             col_last,
  output logic [1:0]       cas_lat,
  output logic             cfg_error
);

  mode_t mode;
  logic [COL_W-1:0] base;
  logic [COL_W-1:0] idx;
  logic [COL_W-1:0] mask;
  logic ilv;

  colgen_mode_reg u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (mode_load),
    .opcode  (mode_opcode),
    .mode    (mode),
    .cfg_err (cfg_error)
  );

  colgen_beat_seq #(.COL_W(COL_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .len_code  (mode.len_code),
    .ilv_mode  (mode.ilv),
    .wr_single (mode.wr_single),
    .start     (burst_start),
    .is_write  (burst_write),
    .start_col (start_col),
    .stop      (burst_stop),
    .ready     (col_ready),
    .active    (col_valid),
    .base      (base),
    .idx       (idx),
    .mask      (mask),
    .ilv       (ilv),
    .last      (col_last)
  );

  colgen_addr_map #(.COL_W(COL_W)) u_map (
    .base (base),
    .idx  (idx),
    .mask (mask),
    .ilv  (ilv),
    .col  (col_addr)
  );

  assign cas_lat = mode.lat_three ? 2'd3 : 2'd2;

endmodule

// File: rtl/colgen_checker.sv
module colgen_checker #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             burst_start,
  input logic [COL_W-1:0] start_col,
  input logic             burst_stop,
  input logic             col_ready,
  input logic             col_valid,
  input logic [COL_W-1:0] col_addr,
  input logic             col_last,
  input logic [1:0]       cas_lat,
  input logic             cfg_error
);

  a_r2_lat_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_lat == 2'd2) || (cas_lat == 2'd3));

  a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error |=> cfg_error);

  a_r4_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |=> col_valid && (col_addr == $past(start_col)));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && !col_ready && !burst_start && !burst_stop
    |=> col_valid && $stable(col_addr) && $stable(col_last));

  a_r11_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> col_valid);

  a_r11_end: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && col_ready && col_last && !burst_start |=> !col_valid);

  a_r12_stop: assert property (@(posedge clk) disable iff (!rst_n)
    burst_stop && !burst_start |=> !col_valid);

  a_r12_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !col_valid && !burst_start |=> !col_valid);

endmodule

bind sdram_burst_colgen colgen_checker #(.COL_W(COL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .burst_start (burst_start),
  .start_col   (start_col),
  .burst_stop  (burst_stop),
  .col_ready   (col_ready),
  .col_valid   (col_valid),
  .col_addr    (col_addr),
  .col_last    (col_last),
  .cas_lat     (cas_lat),
  .cfg_error   (cfg_error)
);

// File: tb/sdram_burst_colgen_bench.sv
module sdram_burst_colgen_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_load = 1'b0;
  logic [11:0] mode_opcode = '0;
  logic burst_start = 1'b0;
  logic burst_write = 1'b0;
  logic [9:0] start_col = '0;
  logic burst_stop = 1'b0;
  logic col_ready = 1'b1;

  logic col_valid, col_last, cfg_error;
  logic [9:0] col_addr;
  logic [1:0] cas_lat;
  logic n_valid, n_last, n_err;
  logic [8:0] n_addr;
  logic [1:0] n_lat;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sdram_burst_colgen #(.COL_W(10)) u_sdram_burst_colgen (
    .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_opcode(mode_opcode),
    .burst_start(burst_start), .burst_write(burst_write), .start_col(start_col),
    .burst_stop(burst_stop), .col_ready(col_ready), .col_valid(col_valid),
    .col_addr(col_addr), .col_last(col_last), .cas_lat(cas_lat), .cfg_error(cfg_error)
  );

  sdram_burst_colgen #(.COL_W(9)) u_sdram_burst_colgen_narrow (
    .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_opcode(mode_opcode),
    .burst_start(burst_start), .burst_write(burst_write), .start_col(start_col[8:0]),
    .burst_stop(burst_stop), .col_ready(col_ready), .col_valid(n_valid),
    .col_addr(n_addr), .col_last(n_last), .cas_lat(n_lat), .cfg_error(n_err)
  );

  typedef struct packed {
    logic [11:0] op;
    logic        wr;
    logic [9:0]  start;
    logic [3:0]  n;
    logic [79:0] seq;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{12'h031, 1'b0, 10'h00B, 4'd2, {10'h00B, 10'h00A, 60'h0}},
    '{12'h032, 1'b0, 10'h1F6, 4'd4, {10'h1F6, 10'h1F7, 10'h1F4, 10'h1F5, 40'h0}},
    '{12'h03A, 1'b0, 10'h1F5, 4'd4, {10'h1F5, 10'h1F4, 10'h1F7, 10'h1F6, 40'h0}},
    '{12'h033, 1'b0, 10'h0D5, 4'd8, {10'h0D5, 10'h0D6, 10'h0D7, 10'h0D0,
                                     10'h0D1, 10'h0D2, 10'h0D3, 10'h0D4}},
    '{12'h03B, 1'b0, 10'h3FD, 4'd8, {10'h3FD, 10'h3FC, 10'h3FF, 10'h3FE,
                                     10'h3F9, 10'h3F8, 10'h3FB, 10'h3FA}},
    '{12'h038, 1'b0, 10'h2A7, 4'd1, {10'h2A7, 70'h0}},
    '{12'h033, 1'b1, 10'h107, 4'd8, {10'h107, 10'h100, 10'h101, 10'h102,
                                     10'h103, 10'h104, 10'h105, 10'h106}},
    '{12'h23B, 1'b1, 10'h123, 4'd1, {10'h123, 70'h0}},
    '{12'h23B, 1'b0, 10'h123, 4'd8, {10'h123, 10'h122, 10'h121, 10'h120,
                                     10'h127, 10'h126, 10'h125, 10'h124}},
    '{12'h039, 1'b0, 10'h3FF, 4'd2, {10'h3FF, 10'h3FE, 60'h0}}
  };

  function automatic string vec_tag(input int i);
    case (i)
      0, 1, 3: return "R5";
      2, 4, 9: return "R6";
      5:       return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load_mode(input logic [11:0] op);
    mode_opcode = op;
    mode_load = 1'b1;
    @(negedge clk);
    mode_load = 1'b0;
  endtask

  task automatic start_burst(input logic [9:0] col, input logic wr);
    start_col = col;
    burst_write = wr;
    burst_start = 1'b1;
    @(negedge clk);
    burst_start = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 valid", col_valid, 0);
    chk("R1 last", col_last, 0);
    chk("R1 err", cfg_error, 0);
    chk("R1 cas", cas_lat, 3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after release", col_valid, 0);
    // R1/R7: default length is one beat
    start_burst(10'h155, 1'b0);
    chk("R4 first addr", col_addr, 10'h155);
    chk("R1 default single last", col_last, 1);
    @(negedge clk);
    chk("R1 default single ends", col_valid, 0);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      load_mode(VECS[v].op);
      start_burst(VECS[v].start, VECS[v].wr);
      for (int k = 0; k < int'(VECS[v].n); k++) begin
        chk({vec_tag(v), " valid"}, col_valid, 1);
        chk({vec_tag(v), " addr"}, col_addr, VECS[v].seq[79-10*k -: 10]);
        chk("R11 last flag", col_last, (k == int'(VECS[v].n) - 1) ? 1 : 0);
        @(negedge clk);
      end
      chk("R11 ends after last", col_valid, 0);
    end

    // R2 / R3: latency and reserved codes
    load_mode(12'h021);
    chk("R2 cas two", cas_lat, 2);
    chk("R2 no err", cfg_error, 0);
    load_mode(12'h054);
    chk("R3 err set", cfg_error, 1);
    chk("R3 cas kept", cas_lat, 2);
    start_burst(10'h010, 1'b0);
    chk("R3 len kept b0", col_addr, 10'h010);
    @(negedge clk);
    chk("R3 len kept b1", col_addr, 10'h011);
    chk("R3 len kept last", col_last, 1);
    @(negedge clk);
    chk("R3 len kept end", col_valid, 0);
    load_mode(12'h033);
    chk("R3 err sticky", cfg_error, 1);
    chk("R2 cas three", cas_lat, 3);

    // R10: back-pressure
    load_mode(12'h032);
    col_ready = 1'b0;
    start_burst(10'h005, 1'b0);
    chk("R10 b0", col_addr, 10'h005);
    @(negedge clk);
    @(negedge clk);
    chk("R10 held addr", col_addr, 10'h005);
    chk("R10 held valid", col_valid, 1);
    chk("R10 held last", col_last, 0);
    col_ready = 1'b1;
    @(negedge clk);
    chk("R10 b1", col_addr, 10'h006);
    @(negedge clk);
    chk("R10 b2", col_addr, 10'h007);
    @(negedge clk);
    chk("R10 b3", col_addr, 10'h004);
    chk("R11 b3 last", col_last, 1);
    @(negedge clk);
    chk("R11 end", col_valid, 0);

    // R13: restart mid-burst
    load_mode(12'h033);
    start_burst(10'h010, 1'b0);
    @(negedge clk);
    chk("R13 pre", col_addr, 10'h011);
    start_burst(10'h020, 1'b0);
    chk("R13 valid", col_valid, 1);
    chk("R13 addr", col_addr, 10'h020);
    @(negedge clk);
    chk("R13 next", col_addr, 10'h021);
    burst_stop = 1'b1;
    @(negedge clk);
    burst_stop = 1'b0;
    chk("R12 stop", col_valid, 0);

    // R8: full page wrap on both widths
    load_mode(12'h037);
    start_burst(10'h3FE, 1'b0);
    chk("R8 w0", col_addr, 10'h3FE);
    chk("R8 n0", n_addr, 9'h1FE);
    @(negedge clk);
    chk("R8 w1", col_addr, 10'h3FF);
    chk("R8 n1", n_addr, 9'h1FF);
    @(negedge clk);
    chk("R8 wide wrap", col_addr, 10'h000);
    chk("R8 narrow wrap", n_addr, 9'h000);
    chk("R8 no last", col_last, 0);
    repeat (1100) @(negedge clk);
    chk("R8 wide long", col_addr, 10'h04C);
    chk("R8 narrow long", n_addr, 9'h04C);
    chk("R8 still valid", col_valid & n_valid, 1);
    chk("R8 never last", col_last | n_last, 0);
    burst_stop = 1'b1;
    @(negedge clk);
    burst_stop = 1'b0;
    chk("R12 stop page", col_valid | n_valid, 0);

    // R12: idle stop, start beats stop
    burst_stop = 1'b1;
    @(negedge clk);
    burst_stop = 1'b0;
    chk("R12 idle stop", col_valid, 0);
    load_mode(12'h033);
    burst_stop = 1'b1;
    start_burst(10'h040, 1'b0);
    burst_stop = 1'b0;
    chk("R12 start wins valid", col_valid, 1);
    chk("R12 start wins addr", col_addr, 10'h040);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule